// File: doc/BRIEF.md
# Serial Bus Register Write Master

This block drives a two-wire serial bus as its only master. It writes one 16-bit value into one 16-bit register address of a single slave. A client offers an address and a value with a valid/ready handshake. The block then plays out one frame on the bus. The frame opens with a start condition and a fixed device byte that already carries the write direction bit. The register address follows as two bytes, high half first, and then the value as two bytes, high half first. A stop condition closes the frame.

The slave must acknowledge each byte by holding SDA low during the ninth clock. When an acknowledge is missing, the block cuts the frame short with a stop and flags the write as failed. SCL is a push-pull level. SDA is open-drain: the block only ever pulls it low or lets it go, and reads the line back through a separate input. The bit rate is set by dividing the system clock. One bit lasts four equal quarters.

Top module: `twr_reg_writer`

## Requirements
- R1: Out of reset and whenever no write is in progress, SCL is high, SDA is released, `req_ready` is 1 and `done` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the cycle of `done`. While it is 0, `req_valid` and the request fields have no effect on the bus.
- R3: A frame starts with SDA falling while SCL is high. SCL is high for the first four quarters, and SDA is released for the first two of them and pulled low for the last two.
- R4: The bytes appear in this order: device byte (0x78 by default), address bits 15..8, address bits 7..0, data bits 15..8, data bits 7..0. Each byte is sent most-significant bit first, with a 1 sent as a released SDA.
- R5: Inside a frame, SDA changes only in the second quarter of a bit, while SCL is low. It never changes while SCL is high.
- R6: The ninth bit of every byte has SDA released from its second quarter onward. The line is sampled at the end of the third quarter, while SCL is high.
- R7: If SDA is high at the acknowledge sample, no further byte is sent. A stop follows at once, and `nack_err` reads 1 in the `done` cycle.
- R8: When all five bytes are acknowledged, `nack_err` reads 0 in the `done` cycle.
- R9: A frame ends with four stop quarters: SCL low with SDA left as it was, SCL low with SDA pulled, SCL high with SDA pulled, then SCL high with SDA released. The last of these forms the rising SDA edge while SCL is high.
- R10: `done` is a one-cycle pulse in the cycle after the last stop quarter, and `req_ready` is 1 in that same cycle.
- R11: Each quarter lasts CLK_HZ/(4*SCL_HZ) clock cycles, so one SCL period is four quarters. The first quarter begins in the cycle right after the accepting edge.
- R12: `nack_err` keeps its value after `done` until the next request is accepted. It is cleared on that accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 16 | Register address to write |
| req_data | input | 16 | Value to write |
| done | output | 1 | One-cycle pulse after the stop condition |
| nack_err | output | 1 | Last write lost an acknowledge |
| scl_o | output | 1 | Serial clock level |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The bench checks both ends of the no-acknowledge path.

- A refusal on the very first byte must yield a one-byte frame. A design that ignored the flag would keep clocking address bytes into a slave that is not listening.
- A refusal on the last byte must still raise the error. A design that decided on the error only when it chose to stop early would report that write as good.

It also checks the quarter where a start hands over to the first data bit and the quarter where an acknowledge hands over to the next byte. A design that moved SDA together with the SCL fall there would produce a false stop or a false start. Finally, it pulses `req_valid` with other fields in the middle of a frame. A design that took that request would corrupt the bytes the slave captures.

// File: rtl/twr_pkg.sv
package twr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_STOP  = 2'd3
  } twr_state_e;

  localparam int FRAME_BYTES = 5;
  localparam logic [3:0] ACK_SLOT = 4'd8;

  // Byte number idx of the frame: device byte, address high/low, data high/low.
  function automatic logic [7:0] frame_byte(input logic [2:0] idx,
                                            input logic [7:0] dev,
                                            input logic [15:0] addr,
                                            input logic [15:0] data);
    logic [7:0] b;
    case (idx)
      3'd0:    b = dev;
      3'd1:    b = addr[15:8];
      3'd2:    b = addr[7:0];
      3'd3:    b = data[15:8];
      default: b = data[7:0];
    endcase
    return b;
  endfunction

  // SCL is high outside the bit slots and in the two later quarters of a slot.
  function automatic logic scl_level(input twr_state_e st, input logic [1:0] ph);
    return (st == ST_IDLE || st == ST_START) ? 1'b1 : ph[1];
  endfunction

  // 1 = pull SDA low. In quarter 0 of a slot the previous level is held.
  function automatic logic sda_pull(input twr_state_e st,
                                    input logic [1:0] ph,
                                    input logic [3:0] bit_idx,
                                    input logic [2:0] byte_idx,
                                    input logic [7:0] cur);
    logic       r;
    logic [2:0] pos;
    r   = 1'b0;
    pos = 3'd0;
    case (st)
      ST_START: r = ph[1];
      ST_BITS: begin
        if (ph == 2'd0) begin
          if (bit_idx == 4'd0) begin
            r = (byte_idx == 3'd0);
          end else begin
            pos = 3'(4'd8 - bit_idx);
            r   = ~cur[pos];
          end
        end else if (bit_idx == ACK_SLOT) begin
          r = 1'b0;
        end else begin
          pos = 3'd7 - bit_idx[2:0];
          r   = ~cur[pos];
        end
      end
      ST_STOP: r = (ph == 2'd1) || (ph == 2'd2);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/twr_quarter_tick.sv
module twr_quarter_tick #(
  parameter int QUARTER = 312
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUARTER - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/twr_frame_seq.sv
module twr_frame_seq
  import twr_pkg::*;
#(
  parameter int NBYTES = FRAME_BYTES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic       tick,
  input  logic       sda_in,
  output twr_state_e state,
  output logic [1:0] phase,
  output logic [3:0] bit_idx,
  output logic [2:0] byte_idx,
  output logic       nack,
  output logic       ack_smp,
  output logic       stop_end,
  output logic       finish
);
  localparam logic [2:0] LAST_BYTE = 3'(NBYTES - 1);

  logic slot_end;

  assign slot_end = tick && (phase == 2'd3);
  assign ack_smp  = tick && (state == ST_BITS) && (bit_idx == ACK_SLOT) && (phase == 2'd2);
  assign stop_end = slot_end && (state == ST_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= 2'd0;
      bit_idx  <= 4'd0;
      byte_idx <= 3'd0;
      nack     <= 1'b0;
      finish   <= 1'b0;
    end else begin
      finish <= stop_end;
      if (state == ST_IDLE) begin
        if (launch) begin
          state    <= ST_START;
          phase    <= 2'd0;
          bit_idx  <= 4'd0;
          byte_idx <= 3'd0;
          nack     <= 1'b0;
        end
      end else if (tick) begin
        phase <= phase + 2'd1;
        if (ack_smp) nack <= sda_in;
        if (slot_end) begin
          case (state)
            ST_START: begin
              state    <= ST_BITS;
              bit_idx  <= 4'd0;
              byte_idx <= 3'd0;
            end
            ST_BITS: begin
              if (bit_idx == ACK_SLOT) begin
                bit_idx <= 4'd0;
                if (nack || byte_idx == LAST_BYTE) state <= ST_STOP;
                else byte_idx <= byte_idx + 3'd1;
              end else begin
                bit_idx <= bit_idx + 4'd1;
              end
            end
            ST_STOP: state <= ST_IDLE;
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/twr_reg_writer.sv
module twr_reg_writer
  import twr_pkg::*;
#(
  parameter int         CLK_HZ   = 125_000_000,
  parameter int         SCL_HZ   = 100_000,
  parameter logic [7:0] DEV_ADDR = 8'h78
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [15:0] req_addr,
  input  logic [15:0] req_data,
  output logic        done,
  output logic        nack_err,
  output logic        scl_o,
  output logic        sda_low_o,
  input  logic        sda_i
);
  localparam int QRAW    = CLK_HZ / (4 * SCL_HZ);
  localparam int QUARTER = (QRAW < 1) ? 1 : QRAW;

  twr_state_e  state;
  logic [1:0]  phase;
  logic [3:0]  bit_idx;
  logic [2:0]  byte_idx;
  logic        tick_w, nack_w, ack_smp_w, stop_end_w, finish_w;
  logic        busy_w, accept_w, bits_w, ack_win_w;
  logic [15:0] addr_q, data_q;
  logic [7:0]  cur_byte_w;
  logic        err_q;

  assign busy_w    = (state != ST_IDLE);
  assign req_ready = !busy_w;
  assign accept_w  = req_valid && req_ready;
  assign bits_w    = (state == ST_BITS);
  assign ack_win_w = bits_w && (bit_idx == ACK_SLOT) && (phase != 2'd0);

  twr_quarter_tick #(.QUARTER(QUARTER)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_w),
    .tick (tick_w)
  );

  twr_frame_seq #(.NBYTES(FRAME_BYTES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (accept_w),
    .tick    (tick_w),
    .sda_in  (sda_i),
    .state   (state),
    .phase   (phase),
    .bit_idx (bit_idx),
    .byte_idx(byte_idx),
    .nack    (nack_w),
    .ack_smp (ack_smp_w),
    .stop_end(stop_end_w),
    .finish  (finish_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (accept_w) begin
      addr_q <= req_addr;
      data_q <= req_data;
      err_q  <= 1'b0;
    end else if (stop_end_w) begin
      err_q  <= nack_w;
    end
  end

  assign cur_byte_w = frame_byte(byte_idx, DEV_ADDR, addr_q, data_q);
  assign scl_o      = scl_level(state, phase);
  assign sda_low_o  = sda_pull(state, phase, bit_idx, byte_idx, cur_byte_w);
  assign done       = finish_w;
  assign nack_err   = err_q;
endmodule

// File: rtl/twr_reg_writer_chk.sv
module twr_reg_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic scl_o,
  input logic sda_low_o,
  input logic busy_w,
  input logic bits_w,
  input logic ack_win_w,
  input logic ack_smp_w
);
  // R1: bus left idle outside a frame
  a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> (scl_o && !sda_low_o));

  // R2: an accepted request closes the handshake on the next cycle
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5: SDA steady while SCL stays high inside the byte slots
  a_r5_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_w && $past(bits_w) && scl_o && $past(scl_o)) |-> $stable(sda_low_o));

  // R6: master lets go of SDA during the acknowledge slot
  a_r6_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
    ack_win_w |-> !sda_low_o);

  // R6: acknowledge sampled while SCL is high
  a_r6_sample_high: assert property (@(posedge clk) disable iff (!rst_n)
    ack_smp_w |-> (scl_o && !sda_low_o));

  // R10: done lasts one cycle and comes with ready
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

bind twr_reg_writer twr_reg_writer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .done     (done),
  .scl_o    (scl_o),
  .sda_low_o(sda_low_o),
  .busy_w   (busy_w),
  .bits_w   (bits_w),
  .ack_win_w(ack_win_w),
  .ack_smp_w(ack_smp_w)
);

// File: tb/twr_reg_writer_test.sv
module twr_reg_writer_test;
  localparam int CLK_HZ = 1_200_000;
  localparam int SCL_HZ = 100_000;
  localparam int Q      = CLK_HZ / (4 * SCL_HZ);  // R11: quarter length in cycles

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic        req_ready, done, nack_err, scl_o, sda_low_o;
  logic        slave_low = 1'b0;
  wire         sda_line = !(sda_low_o || slave_low);

  always #4 clk = ~clk;

  twr_reg_writer #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .done(done), .nack_err(nack_err),
    .scl_o(scl_o), .sda_low_o(sda_low_o), .sda_i(sda_line)
  );

  typedef struct packed {
    bit scl; bit low; bit rdy; bit dn; bit ce; bit er; logic [3:0] tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, bad = 0, cyc = 0;
  bit   armed = 0, ended = 0;

  function automatic string tname(input int t);
    case (t)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic check(input int tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tname(tag), what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  // ---------------- reference model: expected bus per cycle ----------------
  task automatic add(input bit s, input bit l, input int tag);
    exp_t e;
    e = '0; e.scl = s; e.low = l; e.tag = 4'(tag);
    repeat (Q) exp_q.push_back(e);
  endtask

  task automatic build(input logic [15:0] a, input logic [15:0] d, input int nack_at);
    exp_t       e;
    bit         prev;
    logic [39:0] frame;
    logic [7:0]  by;
    e = '0; e.scl = 1; e.rdy = 1; e.tag = 4'd2;
    exp_q.push_back(e);                       // cycle before the accepting edge
    add(1, 0, 3); add(1, 0, 3); add(1, 1, 3); add(1, 1, 3);   // R3 start
    prev  = 1;
    frame = {8'h78, a, d};                    // R4 byte order
    for (int b = 0; b < 5; b++) begin
      by = 8'(frame >> (8 * (4 - b)));
      for (int k = 7; k >= 0; k--) begin       // R4 MSB first, R5 change in quarter 1
        add(0, prev, 5); add(0, !by[k], 5); add(1, !by[k], 5); add(1, !by[k], 5);
        prev = !by[k];
      end
      add(0, prev, 6); add(0, 0, 6); add(1, 0, 6); add(1, 0, 6);  // R6 ack slot
      prev = 0;
      if (b == nack_at) break;                // R7 stop right after refused byte
    end
    add(0, prev, 9); add(0, 1, 9); add(1, 1, 9); add(1, 0, 9);    // R9 stop
    e = '0; e.scl = 1; e.rdy = 1; e.dn = 1; e.ce = 1;
    e.er = (nack_at < 5); e.tag = 4'd10;
    exp_q.push_back(e);                       // R10 done cycle
  endtask

  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (cyc > 150000) begin
      bad++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      finish_run();
    end
    if (armed) begin
      if (exp_q.size() > 0) e = exp_q.pop_front();
      else begin e = '0; e.scl = 1; e.rdy = 1; e.tag = 4'd1; end
      check(11, "scl", scl_o, e.scl);
      check(int'(e.tag), "sda pull", sda_low_o, e.low);
      check(2, "req_ready", req_ready, e.rdy);
      check(10, "done", done, e.dn);
      if (e.ce) check(e.er ? 7 : 8, "nack_err at done", nack_err, e.er);
    end
  end

  // ---------------- behavioural slave ----------------
  int         nack_target = 5;
  logic [7:0] cap [8];
  int         ncap = 0, starts = 0, stops = 0, bitcnt = 0;
  logic [7:0] sh = 0;
  bit         in_frame = 0, pscl = 1, psda = 1;

  always @(negedge clk) begin
    if (scl_o && pscl && psda && !sda_line) begin
      starts++; in_frame = 1; bitcnt = 0; ncap = 0;
    end else if (scl_o && pscl && !psda && sda_line) begin
      stops++; in_frame = 0;
    end else if (in_frame && scl_o && !pscl) begin
      if (bitcnt < 8) sh = {sh[6:0], sda_line};
      bitcnt++;
    end else if (in_frame && !scl_o && pscl) begin
      if (bitcnt == 8) begin
        if (ncap < 8) cap[ncap] = sh;
        slave_low = (ncap != nack_target);
        ncap++;
      end else if (bitcnt == 9) begin
        slave_low = 0; bitcnt = 0;
      end
    end
    pscl = scl_o; psda = sda_line;
  end

  // ---------------- driver ----------------
  task automatic send(input logic [15:0] a, input logic [15:0] d, input int nack_at, input bit ghost);
    int          s0, p0, nexp;
    logic [39:0] frame;
    @(posedge clk); #1;
    while (exp_q.size() != 0) begin @(posedge clk); #1; end
    nack_target = nack_at;
    s0 = starts; p0 = stops;
    req_addr = a; req_data = d; req_valid = 1;
    build(a, d, nack_at);
    @(posedge clk); #1;
    req_valid = 0;
    check(12, "nack_err cleared on accept", nack_err, 0);
    if (ghost) begin
      repeat (100) @(posedge clk);
      #1; req_valid = 1; req_addr = ~a; req_data = ~d;   // R2 must be ignored
      repeat (3) @(posedge clk);
      #1; req_valid = 0;
    end
    while (exp_q.size() != 0) begin @(posedge clk); #1; end
    nexp  = (nack_at < 5) ? nack_at + 1 : 5;
    frame = {8'h78, a, d};
    check(3, "start count", starts - s0, 1);
    check(9, "stop count", stops - p0, 1);
    check(nack_at < 5 ? 7 : 4, "bytes captured", ncap, nexp);
    for (int b = 0; b < nexp; b++)
      check(4, $sformatf("byte %0d", b), cap[b], 8'(frame >> (8 * (4 - b))));
    repeat (20) @(posedge clk);
    #1;
    check(12, "nack_err held", nack_err, (nack_at < 5) ? 1 : 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1, "reset scl", scl_o, 1);
    check(1, "reset sda", sda_low_o, 0);
    check(1, "reset ready", req_ready, 1);
    check(1, "reset done", done, 0);
    rst_n = 1;
    armed = 1;
    send(16'h1234, 16'hABCD, 5, 0);   // R8 full acknowledge
    send(16'hFFFF, 16'h0000, 5, 0);   // R4 extreme bit patterns
    send(16'h0F0F, 16'h8001, 0, 0);   // R7 device byte refused
    send(16'h00FF, 16'hA55A, 5, 1);   // R2 request while busy ignored
    send(16'h3C3C, 16'h7E81, 3, 0);   // R7 data high byte refused
    send(16'hC0DE, 16'h0102, 4, 0);   // R7 last byte refused
    send(16'h5555, 16'hAAAA, 5, 0);   // R12 error cleared by next accept
    repeat (10) @(posedge clk);
    finish_run();
  end
endmodule